// File: doc/BRIEF.md
# Sequential Buffer RAM Access Port with DMA Handshake

This block gives a host a byte-wide (or optionally word-wide) window into a 2K x 8 local buffer RAM. The host never presents a RAM address on every cycle. Instead it loads an 11-bit pointer through two 8-bit pointer registers and then moves data through a single data register. The upper pointer register also carries three control bits: access direction, automatic advance and DMA enable. With automatic advance on, a block of bytes streams through the data register without the pointer being rewritten.

For bulk moves, the host sets the DMA enable bit and writes the lower pointer register. The block then raises a request and performs one RAM access on each falling edge of the acknowledge input. A length value loaded at arming time ends the transfer. Clearing the enable bit during a transfer drops the request at once and lets only one more acknowledge complete. When a transfer finishes, the enable bit clears itself and an interrupt can be raised.

In word mode, pointer bit 0 is no longer an address bit. It selects the byte order on the two data lanes. The mapping also depends on whether the host bus uses separate read/write strobes or a direction/strobe pair.

Top module: `seq_ram_port`

## Requirements
- R1: After reset the pointer is 0x000, direction, auto-advance and DMA enable are 0, `dreq_o` and `irq_o` are 0, and `dma_end_o` is 1.
- R2: Register select 0 is the control/high-pointer register. Bit 7 is direction (1 read, 0 write), bit 6 is auto-advance, bit 3 is DMA enable, and bits 2-0 are pointer bits 10-8. Bits 5-4 read back 0. Select 1 holds pointer bits 7-0. Both registers read back on `rdata_o[7:0]`, with the upper byte 0.
- R3: With auto-advance 1, every data access moves the pointer on by one, wrapping from 0x7FF to 0x000. With auto-advance 0, the pointer holds.
- R4: A host data write (select 2) is ignored while direction is read. A host data read advances the pointer only while direction is read.
- R5: Select 2 returns the RAM byte at the pointer (upper byte 0 in byte mode). It is valid from the second clock after the pointer last changed, so the first read after a pointer load needs no extra wait.
- R6: A write to the low pointer register while DMA enable is 1 raises `dreq_o` on the next clock and loads the beat count from `dma_len_i`.
- R7: During a transfer, each clock in which `dack_i` is low after being high is one beat. A beat makes one RAM access in the current direction (a write takes `wdata_i`) and advances the pointer as a data access does. After the last beat (a count of 0 acts as 1), `dreq_o` drops, DMA enable clears and `dma_end_o` returns to 1.
- R8: Writing the control register with bit 3 at 0 during a transfer drops `dreq_o` on the next clock. The next beat still transfers and then ends the transfer.
- R9: Ending a transfer sets a pending flag. `irq_o` is the flag gated off by `irq_mask_i`. Any pointer register write clears the flag.
- R10: In word mode (`wide_i`=1), each access moves the word row (pointer bits 10-1) by one and keeps pointer bit 0.
- R11: In word mode, pointer bit 0 is the swap bit. With strobe mode (`dirds_mode_i`=0), swap 0 puts the odd byte on bits 15-8 and the even byte on bits 7-0, and swap 1 reverses this. With direction/strobe mode (`dirds_mode_i`=1), swap 0 puts the even byte high, and swap 1 reverses this. The mapping applies to writes and reads alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host register write strobe |
| rd_i | input | 1 | Host register read strobe |
| sel_i | input | 2 | Register select: 0 control/high, 1 low pointer, 2 data |
| wdata_i | input | 16 | Host write data; also DMA write data |
| rdata_o | output | 16 | Read data of the selected register |
| wide_i | input | 1 | Word mode enable |
| dirds_mode_i | input | 1 | Host bus style: 0 read/write strobes, 1 direction/strobe |
| dma_len_i | input | 11 | DMA beat count, loaded at arming |
| dack_i | input | 1 | DMA acknowledge |
| dreq_o | output | 1 | DMA request |
| irq_mask_i | input | 1 | 1 masks the completion interrupt |
| irq_o | output | 1 | Completion interrupt |
| dma_end_o | output | 1 | High whenever DMA enable is 0 |

## Verification
A corrupted pointer shows up one clock later at `rdata_o`. It appears as a wrong low-pointer readback, or as data from the wrong RAM byte two clocks after the step. A stuck or early DMA state shows up as `dreq_o`, `dma_end_o` or `irq_o` disagreeing with the model in the clock after the arming write, the cancel write or the final acknowledge edge. Lane-order errors appear as swapped bytes on the first word read after a word-mode write.

// File: rtl/seq_ram_pkg.sv
package seq_ram_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_HI = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int CtlDirBit  = 7;
  localparam int CtlAincBit = 6;
  localparam int CtlDmaBit  = 3;
  localparam int PtrLoW     = 8;
endpackage

// File: rtl/seq_ram_ptr.sv
module seq_ram_ptr #(
  parameter int ADDR_W = 11,
  parameter int LO_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  input  logic              set_dir_i,
  input  logic              set_ainc_i,
  input  logic              set_en_i,
  input  logic [ADDR_W-LO_W-1:0] set_hi_i,
  input  logic [LO_W-1:0]   set_lo_i,
  input  logic              advance_i,
  input  logic              wide_i,
  input  logic              dma_done_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              dir_rd_o,
  output logic              ainc_o,
  output logic              dma_en_o
);
  localparam int ROW_W = ADDR_W - 1;

  logic [ADDR_W-1:0] ptr_q, ptr_step;
  logic              dir_q, ainc_q, en_q;

  // word mode keeps bit 0 (swap) and steps the row
  always_comb begin
    if (wide_i) ptr_step = {ptr_q[ADDR_W-1:1] + ROW_W'(1), ptr_q[0]};
    else        ptr_step = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      dir_q  <= 1'b0;
      ainc_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (hi_wr_i) begin
        dir_q                   <= set_dir_i;
        ainc_q                  <= set_ainc_i;
        ptr_q[ADDR_W-1:LO_W]    <= set_hi_i;
      end else if (lo_wr_i) begin
        ptr_q[LO_W-1:0]         <= set_lo_i;
      end else if (advance_i && ainc_q) begin
        ptr_q                   <= ptr_step;
      end
      if (hi_wr_i)         en_q <= set_en_i;
      else if (dma_done_i) en_q <= 1'b0;
    end
  end

  assign ptr_o    = ptr_q;
  assign dir_rd_o = dir_q;
  assign ainc_o   = ainc_q;
  assign dma_en_o = en_q;
endmodule

// File: rtl/seq_ram_dma.sv
module seq_ram_dma #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             cancel_i,
  input  logic             clear_pend_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dack_i,
  output logic             dreq_o,
  output logic             beat_o,
  output logic             finish_o,
  output logic             pend_o
);
  logic             active_q, dreq_q, cancel_q, dack_q, pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             beat, last;

  assign beat = active_q && dack_q && !dack_i;
  assign last = (cnt_q <= CNT_W'(1)) || cancel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dreq_q   <= 1'b0;
      cancel_q <= 1'b0;
      dack_q   <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      dack_q <= dack_i;
      if (arm_i) begin
        active_q <= 1'b1;
        dreq_q   <= 1'b1;
        cancel_q <= 1'b0;
        cnt_q    <= len_i;
      end else begin
        if (cancel_i && active_q) begin
          dreq_q   <= 1'b0;
          cancel_q <= 1'b1;
        end
        if (beat) begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (last) begin
            active_q <= 1'b0;
            dreq_q   <= 1'b0;
            cancel_q <= 1'b0;
          end
        end
      end
      if (clear_pend_i)        pend_q <= 1'b0;
      else if (beat && last)   pend_q <= 1'b1;
    end
  end

  assign dreq_o   = dreq_q;
  assign beat_o   = beat;
  assign finish_o = beat && last;
  assign pend_o   = pend_q;
endmodule

// File: rtl/seq_ram_banks.sv
module seq_ram_banks #(
  parameter int ROW_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic                   wide_i,
  input  logic                   lsb_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [1:0][BYTE_W-1:0] wd_i,
  output logic [1:0][BYTE_W-1:0] rd_o
);
  localparam int DEPTH = 1 << ROW_W;

  // bank 0 holds even bytes, bank 1 odd bytes
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;
    logic              bank_we;

    assign bank_we = we_i && (wide_i || (lsb_i == 1'(b)));

    always_ff @(posedge clk_i) begin
      if (bank_we) mem[row_i] <= wd_i[b];
      rd_q <= mem[row_i];
    end

    assign rd_o[b] = rd_q;
  end
endmodule

// File: rtl/seq_ram_lanes.sv
module seq_ram_lanes #(
  parameter int BYTE_W = 8
) (
  input  logic                   wide_i,
  input  logic                   dirds_i,
  input  logic                   swap_i,
  input  logic [2*BYTE_W-1:0]    wdata_i,
  output logic [1:0][BYTE_W-1:0] bank_wd_o,
  input  logic                   rd_wide_i,
  input  logic                   rd_dirds_i,
  input  logic                   rd_swap_i,
  input  logic [1:0][BYTE_W-1:0] bank_rd_i,
  output logic [2*BYTE_W-1:0]    rdata_o
);
  logic hi_odd_w, hi_odd_r;
  logic [BYTE_W-1:0] lane_hi, lane_lo;

  assign hi_odd_w = ~(dirds_i ^ swap_i);
  assign hi_odd_r = ~(rd_dirds_i ^ rd_swap_i);
  assign lane_hi  = wdata_i[2*BYTE_W-1:BYTE_W];
  assign lane_lo  = wdata_i[BYTE_W-1:0];

  always_comb begin
    if (!wide_i) begin
      bank_wd_o[0] = lane_lo;
      bank_wd_o[1] = lane_lo;
    end else if (hi_odd_w) begin
      bank_wd_o[1] = lane_hi;
      bank_wd_o[0] = lane_lo;
    end else begin
      bank_wd_o[0] = lane_hi;
      bank_wd_o[1] = lane_lo;
    end
  end

  always_comb begin
    if (!rd_wide_i)    rdata_o = {{BYTE_W{1'b0}}, bank_rd_i[rd_swap_i]};
    else if (hi_odd_r) rdata_o = {bank_rd_i[1], bank_rd_i[0]};
    else               rdata_o = {bank_rd_i[0], bank_rd_i[1]};
  end
endmodule

// File: rtl/seq_ram_port.sv
module seq_ram_port
  import seq_ram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [1:0]          sel_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  output logic [2*BYTE_W-1:0] rdata_o,
  input  logic                wide_i,
  input  logic                dirds_mode_i,
  input  logic [ADDR_W-1:0]   dma_len_i,
  input  logic                dack_i,
  output logic                dreq_o,
  input  logic                irq_mask_i,
  output logic                irq_o,
  output logic                dma_end_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ROW_W  = ADDR_W - 1;
  localparam int HI_W   = ADDR_W - PtrLoW;

  reg_sel_e          sel;
  logic              hi_wr, lo_wr, cpu_rd, cpu_wr;
  logic              beat, finish, pend, advance, ram_we;
  logic [ADDR_W-1:0] ptr_q;
  logic              dir_rd, ainc, dma_en;
  logic [1:0][BYTE_W-1:0] bank_wd, bank_rd;
  logic              rd_lsb_q, rd_wide_q, rd_dirds_q;
  logic [WORD_W-1:0] data_word;
  logic [BYTE_W-1:0] ctl_byte;

  assign sel    = reg_sel_e'(sel_i);
  assign hi_wr  = wr_i && (sel == SEL_PTR_HI);
  assign lo_wr  = wr_i && (sel == SEL_PTR_LO);
  assign cpu_wr = wr_i && (sel == SEL_DATA) && !dir_rd;
  assign cpu_rd = rd_i && (sel == SEL_DATA) && dir_rd;

  assign advance = cpu_rd || cpu_wr || beat;
  assign ram_we  = cpu_wr || (beat && !dir_rd);

  seq_ram_ptr #(.ADDR_W(ADDR_W), .LO_W(PtrLoW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_wr_i    (hi_wr),
    .lo_wr_i    (lo_wr),
    .set_dir_i  (wdata_i[CtlDirBit]),
    .set_ainc_i (wdata_i[CtlAincBit]),
    .set_en_i   (wdata_i[CtlDmaBit]),
    .set_hi_i   (wdata_i[HI_W-1:0]),
    .set_lo_i   (wdata_i[PtrLoW-1:0]),
    .advance_i  (advance),
    .wide_i     (wide_i),
    .dma_done_i (finish),
    .ptr_o      (ptr_q),
    .dir_rd_o   (dir_rd),
    .ainc_o     (ainc),
    .dma_en_o   (dma_en)
  );

  seq_ram_dma #(.CNT_W(ADDR_W)) u_dma (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (lo_wr && dma_en),
    .cancel_i     (hi_wr && !wdata_i[CtlDmaBit]),
    .clear_pend_i (hi_wr || lo_wr),
    .len_i        (dma_len_i),
    .dack_i       (dack_i),
    .dreq_o       (dreq_o),
    .beat_o       (beat),
    .finish_o     (finish),
    .pend_o       (pend)
  );

  seq_ram_lanes #(.BYTE_W(BYTE_W)) u_lanes (
    .wide_i     (wide_i),
    .dirds_i    (dirds_mode_i),
    .swap_i     (ptr_q[0]),
    .wdata_i    (wdata_i),
    .bank_wd_o  (bank_wd),
    .rd_wide_i  (rd_wide_q),
    .rd_dirds_i (rd_dirds_q),
    .rd_swap_i  (rd_lsb_q),
    .bank_rd_i  (bank_rd),
    .rdata_o    (data_word)
  );

  seq_ram_banks #(.ROW_W(ROW_W), .BYTE_W(BYTE_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .wide_i (wide_i),
    .lsb_i  (ptr_q[0]),
    .row_i  (ptr_q[ADDR_W-1:1]),
    .wd_i   (bank_wd),
    .rd_o   (bank_rd)
  );

  // lane selection must follow the same pointer/mode as the captured bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lsb_q   <= 1'b0;
      rd_wide_q  <= 1'b0;
      rd_dirds_q <= 1'b0;
    end else begin
      rd_lsb_q   <= ptr_q[0];
      rd_wide_q  <= wide_i;
      rd_dirds_q <= dirds_mode_i;
    end
  end

  always_comb begin
    ctl_byte             = '0;
    ctl_byte[CtlDirBit]  = dir_rd;
    ctl_byte[CtlAincBit] = ainc;
    ctl_byte[CtlDmaBit]  = dma_en;
    ctl_byte[HI_W-1:0]   = ptr_q[ADDR_W-1:PtrLoW];
  end

  always_comb begin
    case (sel)
      SEL_PTR_HI: rdata_o = {{BYTE_W{1'b0}}, ctl_byte};
      SEL_PTR_LO: rdata_o = {{BYTE_W{1'b0}}, ptr_q[PtrLoW-1:0]};
      SEL_DATA:   rdata_o = data_word;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o     = pend && !irq_mask_i;
  assign dma_end_o = !dma_en;
endmodule

// File: rtl/seq_ram_port_chk.sv
module seq_ram_port_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              ainc,
  input logic              dma_en,
  input logic              advance,
  input logic              hi_wr,
  input logic              lo_wr,
  input logic              en_bit,
  input logic              wide_i,
  input logic              dreq_o,
  input logic              irq_o,
  input logic              dma_end_o
);
  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && ainc && !wide_i && !hi_wr && !lo_wr) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1)));

  assert_ptr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !ainc && !hi_wr && !lo_wr) |=> $stable(ptr_q));

  assert_swap_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && wide_i && !hi_wr && !lo_wr) |=> (ptr_q[0] == $past(ptr_q[0])));

  assert_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr && dma_en) |=> dreq_o);

  assert_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && !en_bit && dreq_o) |=> !dreq_o);

  assert_req_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> dma_en);

  assert_irq_after_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> dma_end_o);
endmodule

bind seq_ram_port seq_ram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ptr_q     (ptr_q),
  .ainc      (ainc),
  .dma_en    (dma_en),
  .advance   (advance),
  .hi_wr     (hi_wr),
  .lo_wr     (lo_wr),
  .en_bit    (wdata_i[3]),
  .wide_i    (wide_i),
  .dreq_o    (dreq_o),
  .irq_o     (irq_o),
  .dma_end_o (dma_end_o)
);

// File: tb/seq_ram_port_test.sv
module seq_ram_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        wide = 1'b0, dirds = 1'b0;
  logic [10:0] dma_len = 11'd0;
  logic        dack = 1'b0;
  logic        dreq;
  logic        irq_mask = 1'b0;
  logic        irq;
  logic        dma_end;

  always #2 clk = ~clk;

  seq_ram_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .wide_i(wide), .dirds_mode_i(dirds),
    .dma_len_i(dma_len), .dack_i(dack), .dreq_o(dreq), .irq_mask_i(irq_mask),
    .irq_o(irq), .dma_end_o(dma_end)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural reference
  logic [7:0]  m_mem [2048];
  logic [10:0] m_ptr;
  bit          m_dir, m_ainc, m_en, m_active, m_dreq, m_cancel, m_pend, m_dack_q;
  int          m_cnt;
  logic [15:0] m_data;

  function automatic logic [15:0] model_word();
    int row2;
    bit hi_odd;
    if (!wide) return {8'h00, m_mem[m_ptr]};
    row2   = {m_ptr[10:1], 1'b0};
    hi_odd = !(dirds ^ m_ptr[0]);
    return hi_odd ? {m_mem[row2+1], m_mem[row2]} : {m_mem[row2], m_mem[row2+1]};
  endfunction

  task automatic model_store(input logic [15:0] d);
    int row2;
    bit hi_odd;
    if (!wide) m_mem[m_ptr] = d[7:0];
    else begin
      row2   = {m_ptr[10:1], 1'b0};
      hi_odd = !(dirds ^ m_ptr[0]);
      m_mem[row2+1] = hi_odd ? d[15:8] : d[7:0];
      m_mem[row2]   = hi_odd ? d[7:0]  : d[15:8];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = '0; m_dir = 0; m_ainc = 0; m_en = 0; m_active = 0; m_dreq = 0;
      m_cancel = 0; m_pend = 0; m_dack_q = 0; m_cnt = 0; m_data = 'x;
    end else begin : upd
      bit hi_w, lo_w, c_rd, c_wr, beat, last, fin;
      hi_w = wr && sel == 2'd0;
      lo_w = wr && sel == 2'd1;
      c_wr = wr && sel == 2'd2 && !m_dir;
      c_rd = rd && sel == 2'd2 && m_dir;
      beat = m_active && m_dack_q && !dack;
      last = (m_cnt <= 1) || m_cancel;
      fin  = beat && last;
      m_data = model_word();
      if (c_wr || (beat && !m_dir)) model_store(wdata);
      if (lo_w && m_en) begin
        m_active = 1; m_dreq = 1; m_cancel = 0; m_cnt = dma_len;
      end else begin
        if (hi_w && !wdata[3] && m_active) begin m_dreq = 0; m_cancel = 1; end
        if (beat) begin
          m_cnt--;
          if (last) begin m_active = 0; m_dreq = 0; m_cancel = 0; end
        end
      end
      if (hi_w || lo_w) m_pend = 0; else if (fin) m_pend = 1;
      if (hi_w) begin
        m_dir = wdata[7]; m_ainc = wdata[6]; m_ptr[10:8] = wdata[2:0];
      end else if (lo_w) m_ptr[7:0] = wdata[7:0];
      else if ((c_rd || c_wr || beat) && m_ainc)
        m_ptr = wide ? {m_ptr[10:1] + 10'd1, m_ptr[0]} : m_ptr + 11'd1;
      if (hi_w) m_en = wdata[3]; else if (fin) m_en = 0;
      m_dack_q = dack;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin : cmp
      logic [15:0] exp_r;
      case (sel)
        2'd0: exp_r = {8'h00, m_dir, m_ainc, 2'b00, m_en, m_ptr[10:8]};
        2'd1: exp_r = {8'h00, m_ptr[7:0]};
        2'd2: exp_r = m_data;
        default: exp_r = 16'h0;
      endcase
      if ((^exp_r) !== 1'bx) chk(cur_req, "rdata", rdata, exp_r);
      chk(cur_req, "dreq",    {15'h0, dreq},    {15'h0, m_dreq});
      chk(cur_req, "irq",     {15'h0, irq},     {15'h0, m_pend && !irq_mask});
      chk(cur_req, "dma_end", {15'h0, dma_end}, {15'h0, !m_en});
    end
  end

  task automatic host(input logic w, input logic r, input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #1;
    wr = w; rd = r; sel = s; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic dma_beat(input logic [15:0] d);
    @(posedge clk); #1; dack = 1'b1; wdata = d;
    @(posedge clk); #1; dack = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state on both pointer registers and flags
    cur_req = "R1";
    sel = 2'd0; idle(3);
    sel = 2'd1; idle(2);
    // R2: field positions and reserved bits
    cur_req = "R2";
    host(1, 0, 2'd0, 16'h00F7); sel = 2'd0; idle(2);
    host(1, 0, 2'd1, 16'h005A); idle(2);
    host(1, 0, 2'd0, 16'h0000); sel = 2'd0; idle(2);
    // R3: byte writes across the 0x7FF wrap
    cur_req = "R3";
    host(1, 0, 2'd0, 16'h0047);
    host(1, 0, 2'd1, 16'h00FD);
    host(1, 0, 2'd2, 16'h0011);
    host(1, 0, 2'd2, 16'h0022);
    host(1, 0, 2'd2, 16'h0033);
    host(1, 0, 2'd2, 16'h0044);
    sel = 2'd1; idle(2);
    // R5: prefetched reads through the wrap
    cur_req = "R5";
    host(1, 0, 2'd0, 16'h00C7);
    host(1, 0, 2'd1, 16'h00FD);
    sel = 2'd2; idle(1);
    for (int i = 0; i < 4; i++) host(0, 1, 2'd2, 16'h0);
    idle(2);
    // R3: hold with auto-advance off
    cur_req = "R3";
    host(1, 0, 2'd0, 16'h0000);
    host(1, 0, 2'd1, 16'h0010);
    host(1, 0, 2'd2, 16'h0077);
    host(1, 0, 2'd2, 16'h0078);
    sel = 2'd1; idle(2);
    // R4: write ignored in read direction, read ignored in write direction
    cur_req = "R4";
    host(1, 0, 2'd0, 16'h0080);
    host(1, 0, 2'd2, 16'h0099);
    sel = 2'd2; idle(3);
    host(1, 0, 2'd0, 16'h0040);
    host(0, 1, 2'd2, 16'h0);
    sel = 2'd1; idle(2);
    // R6/R7: DMA write of three beats
    cur_req = "R6";
    host(1, 0, 2'd0, 16'h0048);
    dma_len = 11'd3;
    host(1, 0, 2'd1, 16'h0020);
    sel = 2'd0; idle(2);
    cur_req = "R7";
    dma_beat(16'h00A0);
    dma_beat(16'h00A1);
    dma_beat(16'h00A2);
    idle(3);
    // R9: mask and unmask the pending interrupt
    cur_req = "R9";
    irq_mask = 1'b1; idle(3);
    irq_mask = 1'b0; idle(2);
    // R5: read back DMA-written bytes
    cur_req = "R5";
    host(1, 0, 2'd0, 16'h00C0);
    host(1, 0, 2'd1, 16'h0020);
    sel = 2'd2; idle(1);
    for (int i = 0; i < 3; i++) host(0, 1, 2'd2, 16'h0);
    // R7: DMA read of two beats, then a zero-length transfer
    cur_req = "R7";
    host(1, 0, 2'd0, 16'h00C8);
    dma_len = 11'd2;
    host(1, 0, 2'd1, 16'h0020);
    sel = 2'd2;
    dma_beat(16'h0000);
    dma_beat(16'h0000);
    idle(3);
    host(1, 0, 2'd0, 16'h00C8);
    dma_len = 11'd0;
    host(1, 0, 2'd1, 16'h0021);
    sel = 2'd1;
    dma_beat(16'h0000);
    idle(3);
    // R8: cancel mid-transfer, one more beat completes it
    cur_req = "R8";
    host(1, 0, 2'd0, 16'h0048);
    dma_len = 11'd5;
    host(1, 0, 2'd1, 16'h0040);
    sel = 2'd0;
    dma_beat(16'h0055);
    host(1, 0, 2'd0, 16'h0040);
    sel = 2'd0; idle(2);
    dma_beat(16'h0066);
    idle(2);
    dma_beat(16'h0077);
    sel = 2'd1; idle(2);
    host(1, 0, 2'd0, 16'h00C0);
    host(1, 0, 2'd1, 16'h0040);
    sel = 2'd2; idle(1);
    for (int i = 0; i < 3; i++) host(0, 1, 2'd2, 16'h0);
    // R11: word writes with swap=1 under both bus styles
    cur_req = "R11";
    host(1, 0, 2'd0, 16'h0040);
    host(1, 0, 2'd1, 16'h0081);
    wide = 1'b1; dirds = 1'b0;
    host(1, 0, 2'd2, 16'hA1B2);
    dirds = 1'b1;
    host(1, 0, 2'd2, 16'hC3D4);
    // R10: row step of two with swap bit kept
    cur_req = "R10";
    sel = 2'd1; idle(2);
    // R11: read back with swap=0 and swap=1 under both styles
    cur_req = "R11";
    dirds = 1'b0;
    host(1, 0, 2'd0, 16'h00C0);
    host(1, 0, 2'd1, 16'h0080);
    sel = 2'd2; idle(1);
    for (int i = 0; i < 2; i++) host(0, 1, 2'd2, 16'h0);
    dirds = 1'b1;
    host(1, 0, 2'd1, 16'h0081);
    sel = 2'd2; idle(1);
    for (int i = 0; i < 2; i++) host(0, 1, 2'd2, 16'h0);
    dirds = 1'b0;
    host(1, 0, 2'd1, 16'h0080);
    sel = 2'd2; idle(1);
    host(0, 1, 2'd2, 16'h0);
    // R5: byte view of the word-written bytes
    cur_req = "R5";
    wide = 1'b0;
    host(1, 0, 2'd1, 16'h0080);
    sel = 2'd2; idle(1);
    for (int i = 0; i < 4; i++) host(0, 1, 2'd2, 16'h0);
    idle(2);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule